// File: doc/BRIEF.md
# Two-Stage Packet Classifier

This block assigns a 16-bit action code to each packet. Its input is a header record whose fields were already taken out of the packet. The header arrives on a valid/ready input. The block then works in two stages.

In the first stage, the low 32 bits of the record are compared against a 16-entry ternary table. Each table entry holds a value, a care mask and a start address. The entry that wins gives the address where the second stage starts. If no entry wins, the packet gets the discard code.

In the second stage, a small sequencer reads instructions from a 64-word program store. It tests the other 16-bit fields of the record against constants and branches on the outcome. It stops when it reaches an execute instruction, whose immediate becomes the action code. An instruction budget makes sure a bad program still ends with the discard code.

Software or a controller loads both the table and the program store through simple write strobes. These writes must happen while the block is idle. The action code is then held on a valid/ready output until downstream takes it. Only after that is the next header accepted.

Top module: `hdr_classifier`

## Requirements
- R1: After reset `hdr_ready` is 1 and `res_valid` is 0. `hdr_ready` drops in the cycle after a header is taken and stays 0 until the result has been taken.
- R2: The key is `hdr_data[31:0]`. Table entry i matches when its valid bit is 1 and the key equals its value on every bit where its mask bit is 1. Bits where the mask is 0 are don't-care.
- R3: When several entries match, the entry with the lowest index wins.
- R4: When no entry matches, the result is 16'h0000 (discard).
- R5: An instruction is 37 bits wide, laid out as: opcode [36:35], field select [34:32], mask [31:16], immediate [15:0]. The winning entry's address is the first program counter value. COMPARE (opcode 01) takes field f = `hdr_data[16f+15:16f]` and sets the pass flag when ((field XOR immediate) AND mask) is 0; otherwise it clears the flag.
- R6: BRANCH-ON-FAIL (opcode 10) jumps to the address in immediate[5:0] when the flag is clear, and falls through to the next address when the flag is set. The flag is set at the start of every program.
- R7: EXECUTE (opcode 11) ends the program with immediate[15:0] as the result. The result stays valid and unchanged until `res_ready` is seen high.
- R8: A program may execute at most 32 instructions. An EXECUTE that is the 32nd instruction still produces its result. A program that needs a 33rd instruction ends with 16'h0000.
- R9: Opcode 00 is illegal and ends the program with 16'h0000.
- R10: Writing an entry with its valid bit at 0 removes it from matching.
- R11: The program counter wraps from address 63 to address 0 when it falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header record offered |
| hdr_ready | output | 1 | Block can take a header |
| hdr_data | input | 128 | Header record; key in [31:0], eight 16-bit fields |
| tw_en | input | 1 | Table entry write strobe |
| tw_idx | input | 4 | Entry index to write |
| tw_valid | input | 1 | Valid bit for the entry |
| tw_value | input | 32 | Match value |
| tw_mask | input | 32 | Care mask (1 = compare) |
| tw_addr | input | 6 | Program start address |
| pw_en | input | 1 | Program store write strobe |
| pw_addr | input | 6 | Program word address |
| pw_data | input | 37 | Instruction word |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | 16 | Action code |

## Verification
The bench checks three kinds of cases.

- **Two matching entries.** When a key matches both an exact entry and a wider prefix entry, the lower index must win. A reversed priority encoder would run the prefix program and return a different code.
- **Run-away programs.** One program ends exactly at the 32-instruction budget and must still return its code. Another needs one more instruction and must return the discard code. A self-looping program must also return the discard code. An off-by-one counter gives the wrong code at the budget edge, and a missing budget hangs the block.
- **Rarer paths.** These are the wrap from address 63 to 0, the illegal opcode, the initial value of the pass flag, an entry that has been invalidated, and a result held under backpressure. A wrong flag reset value takes the wrong branch. Dropping the result early loses the action code.

// File: rtl/hdr_classifier.sv
module hdr_classifier #(
  parameter int HDR_W      = 128,
  parameter int KEY_W      = 32,
  parameter int KEY_LSB    = 0,
  parameter int FLD_W      = 16,
  parameter int TCAM_N     = 16,
  parameter int PROG_D     = 64,
  parameter int STEP_LIMIT = 32,
  parameter int RES_W      = 16,
  parameter logic [RES_W-1:0] DROP_RES = '0,
  localparam int TIDX_W = $clog2(TCAM_N),
  localparam int PC_W   = $clog2(PROG_D),
  localparam int NFLD   = HDR_W / FLD_W,
  localparam int FSEL_W = $clog2(NFLD),
  localparam int INS_W  = 2 + FSEL_W + 2 * FLD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [HDR_W-1:0]  hdr_data,
  input  logic              tw_en,
  input  logic [TIDX_W-1:0] tw_idx,
  input  logic              tw_valid,
  input  logic [KEY_W-1:0]  tw_value,
  input  logic [KEY_W-1:0]  tw_mask,
  input  logic [PC_W-1:0]   tw_addr,
  input  logic              pw_en,
  input  logic [PC_W-1:0]   pw_addr,
  input  logic [INS_W-1:0]  pw_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [RES_W-1:0]  res_data
);

  localparam int STEP_W = $clog2(STEP_LIMIT + 1);
  localparam logic [1:0] OP_BAD = 2'b00;
  localparam logic [1:0] OP_CMP = 2'b01;
  localparam logic [1:0] OP_BOF = 2'b10;
  localparam logic [1:0] OP_EXE = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_MATCH, S_RUN, S_OUT} state_t;

  state_t             state;
  logic [HDR_W-1:0]   hdr_q;
  logic [PC_W-1:0]    pc;
  logic [STEP_W-1:0]  steps;
  logic               flag;
  logic [RES_W-1:0]   res_q;

  logic               ent_vld [TCAM_N];
  logic [KEY_W-1:0]   ent_val [TCAM_N];
  logic [KEY_W-1:0]   ent_msk [TCAM_N];
  logic [PC_W-1:0]    ent_adr [TCAM_N];
  logic [INS_W-1:0]   prog    [PROG_D];

  logic [TCAM_N-1:0]  hit;
  logic [KEY_W-1:0]   key;
  logic               any_hit;
  logic [PC_W-1:0]    hit_adr;

  assign key = hdr_q[KEY_LSB +: KEY_W];

  for (genvar i = 0; i < TCAM_N; i++) begin : g_ent
    assign hit[i] = ent_vld[i] && (((key ^ ent_val[i]) & ent_msk[i]) == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[i] <= 1'b0;
        ent_val[i] <= '0;
        ent_msk[i] <= '0;
        ent_adr[i] <= '0;
      end else if (tw_en && tw_idx == TIDX_W'(i)) begin
        ent_vld[i] <= tw_valid;
        ent_val[i] <= tw_value;
        ent_msk[i] <= tw_mask;
        ent_adr[i] <= tw_addr;
      end
    end
  end

  always_comb begin
    hit_adr = '0;
    for (int i = TCAM_N - 1; i >= 0; i--)
      if (hit[i]) hit_adr = ent_adr[i];
  end
  assign any_hit = |hit;

  always_ff @(posedge clk)
    if (pw_en) prog[pw_addr] <= pw_data;

  logic [INS_W-1:0]  ins;
  logic [1:0]        op;
  logic [FSEL_W-1:0] fsel;
  logic [FLD_W-1:0]  cmask, imm, field;
  logic              cmp_ok;
  logic [PC_W-1:0]   pc_next;
  logic              budget_out;

  assign ins    = prog[pc];
  assign op     = ins[INS_W-1 -: 2];
  assign fsel   = ins[2*FLD_W +: FSEL_W];
  assign cmask  = ins[FLD_W +: FLD_W];
  assign imm    = ins[0 +: FLD_W];
  assign field  = hdr_q[fsel*FLD_W +: FLD_W];
  assign cmp_ok = ((field ^ imm) & cmask) == '0;
  assign pc_next = (pc == PC_W'(PROG_D - 1)) ? '0 : pc + 1'b1;
  assign budget_out = (steps == STEP_W'(STEP_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hdr_q <= '0;
      pc    <= '0;
      steps <= '0;
      flag  <= 1'b1;
      res_q <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (hdr_valid) begin
            hdr_q <= hdr_data;
            state <= S_MATCH;
          end
        S_MATCH: begin
          pc    <= hit_adr;
          steps <= '0;
          flag  <= 1'b1;
          if (any_hit) state <= S_RUN;
          else begin
            res_q <= DROP_RES;
            state <= S_OUT;
          end
        end
        S_RUN:
          if (budget_out) begin
            res_q <= DROP_RES;
            state <= S_OUT;
          end else begin
            steps <= steps + 1'b1;
            case (op)
              OP_CMP: begin
                flag <= cmp_ok;
                pc   <= pc_next;
              end
              OP_BOF: pc <= flag ? pc_next : imm[PC_W-1:0];
              OP_EXE: begin
                res_q <= imm[RES_W-1:0];
                state <= S_OUT;
              end
              OP_BAD: begin
                res_q <= DROP_RES;
                state <= S_OUT;
              end
              default: ;
            endcase
          end
        S_OUT:
          if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign hdr_ready = (state == S_IDLE);
  assign res_valid = (state == S_OUT);
  assign res_data  = res_q;

endmodule

// File: rtl/hdr_classifier_chk.sv
module hdr_classifier_chk #(
  parameter int STEP_LIMIT = 32,
  parameter int RES_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [RES_W-1:0] res_data
);

  localparam int LIM   = STEP_LIMIT + 1;
  localparam int CNT_W = $clog2(STEP_LIMIT + 4) + 1;

  logic [CNT_W-1:0] busy_cnt;
  logic             busy;

  assign busy = !hdr_ready && !res_valid;

  always_ff @(posedge clk)
    if (!rst_n || !busy) busy_cnt <= '0;
    else                 busy_cnt <= busy_cnt + 1'b1;

  a_r1_no_take_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !hdr_ready);

  a_r1_closed_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_ready);

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && hdr_ready);

  a_r8_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt <= CNT_W'(LIM));

endmodule

bind hdr_classifier hdr_classifier_chk #(.STEP_LIMIT(STEP_LIMIT), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
);

// File: tb/hdr_classifier_tb_top.sv
module hdr_classifier_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hdr_valid = 1'b0;
  logic         hdr_ready;
  logic [127:0] hdr_data = '0;
  logic         tw_en = 1'b0;
  logic [3:0]   tw_idx = '0;
  logic         tw_valid = 1'b0;
  logic [31:0]  tw_value = '0;
  logic [31:0]  tw_mask = '0;
  logic [5:0]   tw_addr = '0;
  logic         pw_en = 1'b0;
  logic [5:0]   pw_addr = '0;
  logic [36:0]  pw_data = '0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [15:0]  res_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdr_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .tw_en(tw_en), .tw_idx(tw_idx), .tw_valid(tw_valid),
    .tw_value(tw_value), .tw_mask(tw_mask), .tw_addr(tw_addr), .pw_en(pw_en),
    .pw_addr(pw_addr), .pw_data(pw_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  function automatic logic [36:0] ins(logic [1:0] op, logic [2:0] f, logic [15:0] m, logic [15:0] i);
    return {op, f, m, i};
  endfunction

  localparam int NV = 12;
  // header = {64'h0, field3, field2, key}
  localparam logic [127:0] V_HDR [NV] = '{
    {64'h0, 16'h0000, 16'h0000, 32'h0A000001},  // R3 exact beats prefix
    {64'h0, 16'h0000, 16'h0050, 32'h0A001234},  // R5 compare pass
    {64'h0, 16'h7711, 16'h0051, 32'h0A001234},  // R6 branch taken, masked pass
    {64'h0, 16'h7712, 16'h0051, 32'h0A001234},  // R6 branch taken, fail
    {64'h0, 16'h0000, 16'h0000, 32'h0B000005},  // R10 invalid entry
    {64'h0, 16'h0000, 16'h0000, 32'h09000000},  // R4 miss
    {64'h0, 16'h0000, 16'h0000, 32'h0C123456},  // R11 wrap, EXE at 32nd step
    {64'h0, 16'h0000, 16'h0000, 32'h0D000000},  // R8 33 steps
    {64'h0, 16'h0000, 16'h0000, 32'h0E000000},  // R8 endless loop
    {64'h0, 16'h0000, 16'h0000, 32'h0F000000},  // R9 illegal opcode
    {64'h0, 16'h0000, 16'h0000, 32'h1A0B0C0D},  // R2 nibble mask hit
    {64'h0, 16'h0000, 16'h0000, 32'h1A0B1C0D}   // R2 nibble mask miss
  };
  localparam logic [15:0] V_RES [NV] = '{
    16'h1001, 16'h2050, 16'h2111, 16'h20FF, 16'h0000, 16'h0000,
    16'h3132, 16'h0000, 16'h0000, 16'h0000, 16'h2425, 16'h0000
  };
  localparam logic [23:0] V_TAG [NV] = '{
    "R3", "R5", "R6", "R6", "R10", "R4", "R11", "R8", "R8", "R9", "R2", "R2"
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr_ent(int idx, bit v, logic [31:0] val, logic [31:0] msk, logic [5:0] a);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 4'(idx); tw_valid = v; tw_value = val; tw_mask = msk; tw_addr = a;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic wr_prog(int a, logic [36:0] d);
    @(negedge clk);
    pw_en = 1'b1; pw_addr = 6'(a); pw_data = d;
    @(negedge clk);
    pw_en = 1'b0;
  endtask

  task automatic send(logic [127:0] h);
    @(negedge clk);
    for (int n = 0; n < 100 && !hdr_ready; n++) @(negedge clk);
    hdr_valid = 1'b1; hdr_data = h;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(!hdr_ready, "R1", {31'b0, hdr_ready}, 32'h0);
  endtask

  task automatic wait_res;
    for (int n = 0; n < 200 && !res_valid; n++) @(negedge clk);
  endtask

  task automatic take;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hdr_ready == 1'b1, "R1", {31'b0, hdr_ready}, 32'h1);
    check(res_valid == 1'b0, "R1", {31'b0, res_valid}, 32'h0);
    rst_n = 1'b1;

    wr_ent(0, 1, 32'h0A000001, 32'hFFFFFFFF, 6'd1);
    wr_ent(1, 1, 32'h0A000000, 32'hFFFF0000, 6'd8);
    wr_ent(2, 0, 32'h0B000000, 32'hFFFF0000, 6'd1);
    wr_ent(3, 1, 32'h0C000000, 32'hFF000000, 6'd33);
    wr_ent(4, 1, 32'h0D000000, 32'hFF000000, 6'd32);
    wr_ent(5, 1, 32'h0E000000, 32'hFF000000, 6'd16);
    wr_ent(6, 1, 32'h0F000000, 32'hFF000000, 6'd20);
    wr_ent(7, 1, 32'h10000000, 32'hF0F0F0F0, 6'd24);

    wr_prog(1,  ins(2'b11, 3'd0, 16'h0, 16'h1001));
    wr_prog(8,  ins(2'b01, 3'd2, 16'hFFFF, 16'h0050));
    wr_prog(9,  ins(2'b10, 3'd0, 16'h0, 16'd12));
    wr_prog(10, ins(2'b11, 3'd0, 16'h0, 16'h2050));
    wr_prog(12, ins(2'b01, 3'd3, 16'h00FF, 16'h0011));
    wr_prog(13, ins(2'b10, 3'd0, 16'h0, 16'd15));
    wr_prog(14, ins(2'b11, 3'd0, 16'h0, 16'h2111));
    wr_prog(15, ins(2'b11, 3'd0, 16'h0, 16'h20FF));
    wr_prog(16, ins(2'b01, 3'd0, 16'hFFFF, 16'hFFFF));
    wr_prog(17, ins(2'b10, 3'd0, 16'h0, 16'd16));
    wr_prog(20, ins(2'b00, 3'd0, 16'h0, 16'h5555));
    wr_prog(24, ins(2'b10, 3'd0, 16'h0, 16'd26));
    wr_prog(25, ins(2'b11, 3'd0, 16'h0, 16'h2425));
    wr_prog(26, ins(2'b11, 3'd0, 16'h0, 16'h2426));
    for (int a = 32; a < 64; a++) wr_prog(a, ins(2'b10, 3'd0, 16'h0, 16'd20));
    wr_prog(0, ins(2'b11, 3'd0, 16'h0, 16'h3132));

    for (int v = 0; v < NV; v++) begin
      send(V_HDR[v]);
      wait_res();
      check(res_valid && res_data == V_RES[v], string'(V_TAG[v]), {15'b0, res_valid, res_data}, {16'h1, V_RES[v]});
      take();
    end

    // R7: result held under backpressure, R1: no new header taken meanwhile
    send(V_HDR[1]);
    wait_res();
    hdr_valid = 1'b1; hdr_data = V_HDR[0];
    repeat (5) @(negedge clk);
    check(res_valid && res_data == 16'h2050, "R7", {15'b0, res_valid, res_data}, {16'h1, 16'h2050});
    check(!hdr_ready, "R1", {31'b0, hdr_ready}, 32'h0);
    hdr_valid = 1'b0;
    take();
    check(!res_valid, "R7", {31'b0, res_valid}, 32'h0);

    // R10: invalidate entry 0, key now falls to prefix entry 1
    wr_ent(0, 0, 32'h0A000001, 32'hFFFFFFFF, 6'd1);
    send(V_HDR[0]);
    wait_res();
    check(res_valid && res_data == 16'h20FF, "R10", {15'b0, res_valid, res_data}, {16'h1, 16'h20FF});
    take();

    done = 1'b1;
    report();
  end

endmodule